// File: doc/BRIEF.md
# Framebuffer Word Pixel Unpacker

This block turns a stream of 32-bit framebuffer words into a stream of 24-bit colour pixels, one pixel per cycle. Each word comes in on a valid/ready handshake. The block splits the word into the pixels it holds and sends them out on a second valid/ready handshake. The mode is picked per line. There are four indexed depths (1, 2, 4 and 8 bits per pixel), three 16-bit direct formats (565, 555 and 444) and a 32-bit direct format. Each mode can be combined with one of three memory orderings and with a red/blue exchange.

In the indexed depths the block puts the pixel index on a palette read port. The palette answers one cycle later, and that answer becomes the output pixel. The direct formats widen their colour fields to 8 bits by shifting them left.

A line starts when the line start strobe is pulsed while no line is running. The strobe loads the pixel count and the mode. The block emits exactly that many pixels. Any pixels left over in the final word are dropped. Word fetch addressing and panel timing are handled elsewhere.

Top module: `fb_pixel_unpacker`

## Requirements
- R1: While reset is held, and after it until a line is started, `pix_valid_o`, `word_ready_o` and `pal_req_o` are all 0.
- R2: A line emits exactly `line_len_i` pixels, with `pix_last_o` set on the final one only. The number of pixels per word is 32, 16, 8 and 4 for depth codes 0 to 3, 2 for codes 4 to 6, and 1 for code 7. `word_ready_o` is 0 once the line is complete, so the unused pixels of the last word are dropped and the next line begins with a fresh word.
- R3: With order code 0, pixel 0 is taken from the least significant bits of the word and later pixels come from successively higher bits.
- R4: With order code 1, the word is byte-reversed before unpacking, so bytes are used from bits [31:24] downward. This also applies to the 16-bit and 32-bit formats.
- R5: With order code 2, bytes are used from low to high. Inside each byte, the pixels narrower than 8 bits are taken from the most significant end first. For 8-bit and wider pixels this order is the same as order code 0.
- R6: For depth codes 0 to 3, `pal_req_o` is raised with the index on `pal_idx_o`. The output pixel is the `pal_rgb_i` value of the following cycle. A pixel reaches the output 3 cycles after its word is accepted; a direct-format pixel takes 2 cycles.
- R7: Depth code 4 (565) splits each halfword into fields of 5, 6 and 5 bits from the low end. The fields are widened by left shifts of 3, 2 and 3.
- R8: Depth code 5 (555) uses three 5-bit fields per halfword, each shifted left by 3. Bit 15 of the halfword is ignored.
- R9: Depth code 6 (444) uses three 4-bit fields in bits [11:0] of each halfword, each shifted left by 4. Bits [15:12] are ignored.
- R10: Depth code 7 takes its fields from bits [7:0], [15:8] and [23:16] of the ordered word. The remaining byte is ignored.
- R11: For direct formats, `pix_rgb_o` is {red[23:16], green[15:8], blue[7:0]}. With `bgr_i`=0 the lowest field is red and the highest is blue; with `bgr_i`=1 these two are exchanged. Indexed pixels pass the palette value through unchanged.
- R12: The mode, order, swap and length inputs take effect only on a `line_start_i` pulse while no line is running. A pulse during a line has no effect.
- R13: While `pix_valid_o` is 1 and `pix_ready_i` is 0, the output pixel and its last flag stay unchanged. No pixel is lost or repeated under backpressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Starts a line and loads the configuration when idle |
| line_len_i | input | LEN_W | Pixels in the line |
| depth_i | input | 3 | Depth code 0..7 (1, 2, 4, 8 bpp, 565, 555, 444, 32-bit) |
| order_i | input | 2 | Memory order code 0..2 (3 acts as 0) |
| bgr_i | input | 1 | Exchange red and blue for direct formats |
| word_valid_i | input | 1 | Input word valid |
| word_data_i | input | 32 | Input framebuffer word |
| word_ready_o | output | 1 | Input word accepted when high with valid |
| pal_req_o | output | 1 | Palette read strobe |
| pal_idx_o | output | 8 | Palette index |
| pal_rgb_i | input | 24 | Palette data, one cycle after the strobe |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_ready_i | input | 1 | Output pixel accepted |
| pix_rgb_o | output | 24 | Output pixel {R,G,B} |
| pix_last_o | output | 1 | Final pixel of the line |

## Verification
A wrong slot counter or wrong ordering state shows up at the ports as a misplaced pixel. With backpressure switched off, this appears within two or three cycles of the word being accepted. A wrong remaining-length count shows up either as a missing or extra pixel at the end of the line, or as `word_ready_o` still asserted after the line ends. Lost palette data under a stall shows up as a pixel that does not match the palette value for its index.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;
  localparam int IDX_W  = 8;
  localparam int SLOT_W = 5;

  localparam logic [2:0] DEP_1   = 3'd0;
  localparam logic [2:0] DEP_2   = 3'd1;
  localparam logic [2:0] DEP_4   = 3'd2;
  localparam logic [2:0] DEP_8   = 3'd3;
  localparam logic [2:0] DEP_565 = 3'd4;
  localparam logic [2:0] DEP_555 = 3'd5;
  localparam logic [2:0] DEP_444 = 3'd6;
  localparam logic [2:0] DEP_32  = 3'd7;

  localparam logic [1:0] ORD_LL = 2'd0;
  localparam logic [1:0] ORD_BB = 2'd1;
  localparam logic [1:0] ORD_LB = 2'd2;

  // log2 of bits per pixel
  function automatic logic [2:0] depth_log2(input logic [2:0] d);
    if (d <= DEP_8)       return d;
    else if (d == DEP_32) return 3'd5;
    else                  return 3'd4;
  endfunction

  function automatic logic is_indexed(input logic [2:0] d);
    return d <= DEP_8;
  endfunction
endpackage

// File: rtl/fbu_extract.sv
module fbu_extract
  import fbu_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [2:0]        depth_i,
  input  logic [1:0]        order_i,
  input  logic              bgr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PIX_W-1:0]  rgb_o
);
  logic [WORD_W-1:0] norm, sh;
  logic [2:0]        lb;
  logic [5:0]        off;
  logic [15:0]       h;
  logic [7:0]        lo, mid, hi, mask;
  logic [7:0]        unused_top;

  always_comb begin
    lb   = depth_log2(depth_i);
    norm = (order_i == ORD_BB) ?
           {word_i[7:0], word_i[15:8], word_i[23:16], word_i[31:24]} : word_i;
    off  = {1'b0, slot_i} << lb;
    // sub-byte pixels taken from the top of each byte
    if (order_i == ORD_LB && lb < 3'd3)
      off[2:0] = off[2:0] ^ (3'b111 << lb);
    sh = norm >> off[4:0];
    case (lb)
      3'd0:    mask = 8'h01;
      3'd1:    mask = 8'h03;
      3'd2:    mask = 8'h0f;
      default: mask = 8'hff;
    endcase
    idx_o = sh[7:0] & mask;
    h     = sh[15:0];
    case (depth_i)
      DEP_565: begin
        lo = {h[4:0], 3'b0}; mid = {h[10:5], 2'b0}; hi = {h[15:11], 3'b0};
      end
      DEP_555: begin
        lo = {h[4:0], 3'b0}; mid = {h[9:5], 3'b0};  hi = {h[14:10], 3'b0};
      end
      DEP_444: begin
        lo = {h[3:0], 4'b0}; mid = {h[7:4], 4'b0};  hi = {h[11:8], 4'b0};
      end
      default: begin
        lo = sh[7:0]; mid = sh[15:8]; hi = sh[23:16];
      end
    endcase
    rgb_o      = bgr_i ? {hi, mid, lo} : {lo, mid, hi};
    unused_top = sh[31:24];
  end
endmodule

// File: rtl/fbu_word_stage.sv
module fbu_word_stage
  import fbu_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic [2:0]        depth_i,
  input  logic [1:0]        order_i,
  input  logic              bgr_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  input  logic              can_emit_i,
  output logic              emit_o,
  output logic              last_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [2:0]        depth_o,
  output logic [1:0]        order_o,
  output logic              bgr_o
);
  logic [LEN_W-1:0]  rem_q;
  logic [WORD_W-1:0] w_q;
  logic              w_valid_q;
  logic [SLOT_W-1:0] slot_q, slot_max;
  logic [2:0]        depth_q;
  logic [1:0]        order_q;
  logic              bgr_q;
  logic              active, last_slot, fin, take;

  assign slot_max     = SLOT_W'(5'd31 >> depth_log2(depth_q));
  assign active       = rem_q != '0;
  assign last_slot    = slot_q == slot_max;
  assign emit_o       = w_valid_q && can_emit_i;
  assign fin          = emit_o && rem_q == LEN_W'(1);
  assign word_ready_o = active && (!w_valid_q || (emit_o && last_slot && !fin));
  assign take         = word_valid_i && word_ready_o;
  assign last_o       = rem_q == LEN_W'(1);
  assign word_o       = w_q;
  assign slot_o       = slot_q;
  assign depth_o      = depth_q;
  assign order_o      = order_q;
  assign bgr_o        = bgr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      w_q       <= '0;
      w_valid_q <= 1'b0;
      slot_q    <= '0;
      depth_q   <= '0;
      order_q   <= '0;
      bgr_q     <= 1'b0;
    end else if (line_start_i && !active) begin
      rem_q   <= line_len_i;
      depth_q <= depth_i;
      order_q <= order_i;
      bgr_q   <= bgr_i;
      slot_q  <= '0;
    end else begin
      if (emit_o) begin
        rem_q <= rem_q - LEN_W'(1);
        if (fin || last_slot) begin
          slot_q    <= '0;
          w_valid_q <= 1'b0;
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end
      if (take) begin
        w_q       <= word_data_i;
        w_valid_q <= 1'b1;
      end
    end
  end

  // R2
  no_word_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !w_valid_q);
  // R2
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_valid_q |-> slot_q <= slot_max);
  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |=> $stable(depth_q) && $stable(order_q) && $stable(bgr_q));
endmodule

// File: rtl/fbu_pix_out.sv
module fbu_pix_out
  import fbu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_i,
  input  logic             indexed_i,
  input  logic             last_i,
  input  logic [PIX_W-1:0] rgb_i,
  input  logic [PIX_W-1:0] pal_rgb_i,
  output logic             can_emit_o,
  input  logic             pix_ready_i,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_rgb_o,
  output logic             pix_last_o
);
  logic             lk_valid_q, lk_fresh_q, lk_last_q;
  logic [PIX_W-1:0] lk_rgb_q, lk_data;
  logic             out_valid_q, out_last_q;
  logic [PIX_W-1:0] out_rgb_q;
  logic             adv;

  assign adv        = !out_valid_q || pix_ready_i;
  // direct pixels must not overtake a pending palette lookup
  assign can_emit_o = indexed_i ? (!lk_valid_q || adv) : (!lk_valid_q && adv);
  assign lk_data    = lk_fresh_q ? pal_rgb_i : lk_rgb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_q  <= 1'b0;
      lk_fresh_q  <= 1'b0;
      lk_last_q   <= 1'b0;
      lk_rgb_q    <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_rgb_q   <= '0;
    end else begin
      lk_fresh_q <= emit_i && indexed_i;
      if (lk_fresh_q) lk_rgb_q <= pal_rgb_i;
      if (emit_i && indexed_i) begin
        lk_valid_q <= 1'b1;
        lk_last_q  <= last_i;
      end else if (adv) begin
        lk_valid_q <= 1'b0;
      end
      if (adv) begin
        if (lk_valid_q) begin
          out_valid_q <= 1'b1;
          out_rgb_q   <= lk_data;
          out_last_q  <= lk_last_q;
        end else if (emit_i && !indexed_i) begin
          out_valid_q <= 1'b1;
          out_rgb_q   <= rgb_i;
          out_last_q  <= last_i;
        end else begin
          out_valid_q <= 1'b0;
        end
      end
    end
  end

  assign pix_valid_o = out_valid_q;
  assign pix_rgb_o   = out_rgb_q;
  assign pix_last_o  = out_last_q;

  // R13
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q && !pix_ready_i |=> out_valid_q && $stable(out_rgb_q) && $stable(out_last_q));
  // R13
  lk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_q && !adv |=> lk_valid_q);
  // R6
  no_overtake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i && !indexed_i |-> !lk_valid_q);
  // R6
  fresh_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fresh_q |-> lk_valid_q);
endmodule

// File: rtl/fb_pixel_unpacker.sv
module fb_pixel_unpacker
  import fbu_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic [2:0]        depth_i,
  input  logic [1:0]        order_i,
  input  logic              bgr_i,
  input  logic              word_valid_i,
  input  logic [31:0]       word_data_i,
  output logic              word_ready_o,
  output logic              pal_req_o,
  output logic [7:0]        pal_idx_o,
  input  logic [23:0]       pal_rgb_i,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic [23:0]       pix_rgb_o,
  output logic              pix_last_o
);
  logic              emit, last, can_emit, bgr, indexed;
  logic [WORD_W-1:0] word;
  logic [SLOT_W-1:0] slot;
  logic [2:0]        depth;
  logic [1:0]        order;
  logic [IDX_W-1:0]  idx;
  logic [PIX_W-1:0]  rgb;

  fbu_word_stage #(.LEN_W(LEN_W)) u_word (
    .clk_i, .rst_ni, .line_start_i, .line_len_i, .depth_i, .order_i, .bgr_i,
    .word_valid_i, .word_data_i, .word_ready_o,
    .can_emit_i(can_emit), .emit_o(emit), .last_o(last), .word_o(word),
    .slot_o(slot), .depth_o(depth), .order_o(order), .bgr_o(bgr)
  );

  fbu_extract u_ext (
    .word_i(word), .slot_i(slot), .depth_i(depth), .order_i(order),
    .bgr_i(bgr), .idx_o(idx), .rgb_o(rgb)
  );

  assign indexed   = is_indexed(depth);
  assign pal_req_o = emit && indexed;
  assign pal_idx_o = idx;

  fbu_pix_out u_out (
    .clk_i, .rst_ni, .emit_i(emit), .indexed_i(indexed), .last_i(last),
    .rgb_i(rgb), .pal_rgb_i, .can_emit_o(can_emit), .pix_ready_i,
    .pix_valid_o, .pix_rgb_o, .pix_last_o
  );
endmodule

// File: tb/fb_pixel_unpacker_test.sv
`timescale 1ns/1ps
module fb_pixel_unpacker_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_start_i = 1'b0;
  logic [11:0] line_len_i = '0;
  logic [2:0]  depth_i = '0;
  logic [1:0]  order_i = '0;
  logic        bgr_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_data_i = '0;
  logic        word_ready_o, pal_req_o, pix_valid_o, pix_last_o;
  logic        pix_ready_i = 1'b1;
  logic [7:0]  pal_idx_o;
  logic [23:0] pal_rgb_i = '0;
  logic [23:0] pix_rgb_o;

  always #5 clk = ~clk;

  fb_pixel_unpacker uut (.*, .clk_i(clk));

  int total = 0, bad = 0;
  int cd, co, cb, cw, got;
  bit bp_en = 1'b0;
  logic [31:0] words [4];
  logic [31:0] seed = 32'h1234_5678;
  logic [15:0] bp_lfsr = 16'hace1;
  bit done = 1'b0;

  function automatic logic [23:0] palf(input logic [7:0] i);
    return {i, i ^ 8'hff, i + 8'h31};
  endfunction

  // palette model: one cycle read latency
  always @(posedge clk) pal_rgb_i <= pal_req_o ? palf(pal_idx_o) : 24'hdead00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int lb_of(input int d);
    return d < 4 ? d : (d == 7 ? 5 : 4);
  endfunction

  function automatic logic [23:0] exp_rgb(input int k);
    int lb, ppw, s, b, per, bi, sub, sh, v, lo, mid, hi;
    logic [31:0] w;
    logic [7:0] byt;
    logic [15:0] h;
    lb = lb_of(cd); ppw = 32 >> lb;
    w = words[k / ppw]; s = k % ppw;
    if (cd < 4) begin
      b = 1 << lb; per = 8 / b; bi = s / per; sub = s % per;
      byt = (co == 1) ? w[8*(3-bi) +: 8] : w[8*bi +: 8];
      sh = (co == 2) ? 8 - b - sub*b : sub*b;
      v = (int'(byt) >> sh) & ((1 << b) - 1);
      return palf(8'(v));
    end
    if (cd == 7) begin
      if (co == 1) begin lo = w[31:24]; mid = w[23:16]; hi = w[15:8]; end
      else         begin lo = w[7:0];   mid = w[15:8];  hi = w[23:16]; end
    end else begin
      if (co == 1) h = (s == 0) ? {w[23:16], w[31:24]} : {w[7:0], w[15:8]};
      else         h = (s == 0) ? w[15:0] : w[31:16];
      if (cd == 4) begin
        lo = (h % 32) * 8; mid = ((h / 32) % 64) * 4; hi = ((h / 2048) % 32) * 8;
      end else if (cd == 5) begin
        lo = (h % 32) * 8; mid = ((h / 32) % 32) * 8; hi = ((h / 1024) % 32) * 8;
      end else begin
        lo = (h % 16) * 16; mid = ((h / 16) % 16) * 16; hi = ((h / 256) % 16) * 16;
      end
    end
    return cb ? {8'(hi), 8'(mid), 8'(lo)} : {8'(lo), 8'(mid), 8'(hi)};
  endfunction

  function automatic string tag_of();
    string t;
    t = (co == 0) ? "R3" : (co == 1) ? "R4" : "R5";
    case (cd)
      0, 1, 2, 3: t = {t, " R6"};
      4: t = {t, " R7"};
      5: t = {t, " R8"};
      6: t = {t, " R9"};
      default: t = {t, " R10"};
    endcase
    if (cb != 0 && cd > 3) t = {t, " R11"};
    return t;
  endfunction

  // output monitor
  initial begin
    bit held_v = 1'b0;
    logic [23:0] held_rgb = '0;
    logic held_last = 1'b0;
    forever begin
      @(negedge clk);
      bp_lfsr = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
      pix_ready_i = bp_en ? (bp_lfsr[0] | bp_lfsr[3]) : 1'b1;
      #1;
      if (held_v)
        chk(pix_valid_o && pix_rgb_o == held_rgb && pix_last_o == held_last,
            "R13 stalled pixel changed", {8'h0, pix_rgb_o}, {8'h0, held_rgb});
      held_v = pix_valid_o && !pix_ready_i;
      held_rgb = pix_rgb_o; held_last = pix_last_o;
      if (pix_valid_o && pix_ready_i && rst_ni) begin
        if (got >= cw) chk(1'b0, "R2 extra pixel", got, cw);
        else begin
          chk(pix_rgb_o == exp_rgb(got), tag_of(), {8'h0, pix_rgb_o}, {8'h0, exp_rgb(got)});
          chk(pix_last_o == (got == cw - 1), "R2 last flag", pix_last_o, (got == cw - 1));
        end
        got++;
      end
    end
  end

  task automatic run_line(input int d, input int o, input int b, input int len, input bit glitch);
    int ppw, nw, t, bad0;
    logic [31:0] force_m;
    ppw = 32 >> lb_of(d);
    nw = (len + ppw - 1) / ppw;
    force_m = (d == 5) ? 32'h8000_8000 : (d == 6) ? 32'hf000_f000 :
              (d == 7) ? ((o == 1) ? 32'h0000_00ff : 32'hff00_0000) : 32'h0;
    if (d == 5 || d == 6) force_m = (o == 1) ? {force_m[7:0], force_m[15:8], force_m[23:16], force_m[31:24]} : force_m;
    for (int i = 0; i < 4; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      words[i] = seed ^ {seed[15:0], seed[31:16]} | force_m;
    end
    cd = d; co = o; cb = b; cw = len; got = 0; bad0 = bad;
    @(negedge clk);
    line_start_i = 1'b1; depth_i = 3'(d); order_i = 2'(o); bgr_i = b[0]; line_len_i = 12'(len);
    @(negedge clk);
    line_start_i = 1'b0; depth_i = ~3'(d); order_i = 2'(o + 1); bgr_i = ~b[0]; line_len_i = 12'd1;
    for (int i = 0; i < nw; i++) begin
      word_valid_i = 1'b1; word_data_i = words[i];
      #1;
      t = 0;
      while (!word_ready_o && t < 2000) begin @(negedge clk); #1; t++; end
      @(negedge clk);
      if (glitch && i == 0)
        fork begin line_start_i = 1'b1; @(negedge clk); line_start_i = 1'b0; end join_none
    end
    word_valid_i = 1'b0;
    t = 0;
    while (got < cw && t < 4000) begin @(negedge clk); t++; end
    #2;
    chk(got == cw, "R2 pixel count", got, cw);
    chk(!word_ready_o, "R2 ready after line end", word_ready_o, 0);
    if (glitch) chk(bad == bad0, "R12 mid-line start altered line", bad - bad0, 0);
  endtask

  task automatic latency(input int d, input int expc);
    int c;
    bp_en = 1'b0;
    words[0] = 32'h5a3c_96e1;
    cd = d; co = 0; cb = 0; cw = 1; got = 0;
    @(negedge clk);
    line_start_i = 1'b1; depth_i = 3'(d); order_i = 2'd0; bgr_i = 1'b0; line_len_i = 12'd1;
    @(negedge clk);
    line_start_i = 1'b0; word_valid_i = 1'b1; word_data_i = words[0];
    #1;
    chk(word_ready_o, "R2 ready at line start", word_ready_o, 1);
    @(negedge clk);
    word_valid_i = 1'b0; c = 1;
    #1;
    while (!pix_valid_o && c < 10) begin @(negedge clk); c++; #1; end
    chk(c == expc, "R6 latency", c, expc);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_all();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      finish_all();
    end
  end

  initial begin
    cw = 0; got = 0;
    repeat (3) @(negedge clk);
    chk(!pix_valid_o && !word_ready_o && !pal_req_o, "R1 in reset",
        {pix_valid_o, word_ready_o, pal_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    word_valid_i = 1'b1;
    #1;
    chk(!pix_valid_o && !word_ready_o && !pal_req_o, "R1 idle after reset",
        {pix_valid_o, word_ready_o, pal_req_o}, 0);
    @(negedge clk);
    word_valid_i = 1'b0;
    latency(7, 2);
    latency(3, 3);
    bp_en = 1'b1;
    for (int d = 0; d < 8; d++)
      for (int o = 0; o < 3; o++)
        for (int b = 0; b < 2; b++) begin
          int ppw;
          ppw = 32 >> lb_of(d);
          run_line(d, o, b, 2*ppw + (ppw + 1)/2, b == 1);
        end
    bp_en = 1'b0;
    run_line(4, 0, 0, 3, 1'b0);
    run_line(0, 2, 0, 5, 1'b0);
    done = 1'b1;
    finish_all();
  end
endmodule